// File: doc/BRIEF.md
# Inline-Encryption Key Slot Register File

This block holds the key slots that a storage host controller's inline-encryption datapath uses. Software programs each slot through a simple 32-bit register port. Each slot holds a 512-bit key, a control dword and one extra configuration dword. The datapath names a slot index on a separate lookup port. One cycle later it receives the slot's valid flag, key, capability index and data-unit-size mask.

A capability register at offset zero reports two values: how many slots exist, and where the slot array starts in the register space. Software uses these to find every slot. The enable bit in the control dword is the commit point for a slot. Software clears it, writes the key and the extra dword, then sets it again with the control write. Key and extra writes that reach a slot while it is enabled are dropped. A datapath can therefore never see a key that is only partly written. Keys cannot be read back over the register port.

Top module: `crypto_keyslot_regs`

## Requirements
- R1: The register at byte offset 0x000 reads `NUM_SLOTS-1` in bits 7:0 and `ARRAY_PTR` in bits 23:16, with all other bits zero. Writes to it have no effect.
- R2: Dword d of slot s is at byte address `ARRAY_PTR*0x100 + s*0x80 + d*4`. Every slot, including the last one, decodes independently.
- R3: Key dwords 0 to 15 of every slot always read as zero.
- R4: Control dword 16 stores the data-unit mask in bits 7:0, the capability index in bits 15:8 and the enable bit in bit 31. It reads back exactly those fields, and bits 30:16 read zero.
- R5: Extra dword 17 stores and reads back all 32 bits.
- R6: Dwords 18 to 31 of a slot, and every address that is neither the capability register nor inside the slot array, read zero. Writes to them change no slot.
- R7: While a slot's enable bit is set, writes to its key dwords and its extra dword are ignored. Once enable is cleared, they take effect again.
- R8: A lookup returns the result one cycle after `lk_idx` is sampled. `lk_valid` equals the slot's enable bit. The key maps dword k to `lk_key[32k+31:32k]`, and capability index and mask are also returned. When the result is invalid, key, index and mask are all zero.
- R9: A lookup index of `NUM_SLOTS` or above returns invalid.
- R10: Reset clears every slot's key, control and extra dword.
- R11: `reg_rdata` presents the read result one cycle after `reg_rd_en` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address, dword aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the strobe |
| lk_idx | input | LK_IDX_W | Datapath slot index |
| lk_valid | output | 1 | Slot enabled and index in range |
| lk_key | output | 512 | Slot key |
| lk_cap_idx | output | 8 | Slot capability index |
| lk_dus_mask | output | 8 | Slot data-unit-size mask |

## Verification
The hardest case to reach is a key write arriving at a slot that is already enabled, followed by a proper disable, rewrite and re-enable. The stimulus programs a slot, sends key and extra writes while it is live, and shows through a lookup and a readback that nothing changed. It then clears enable with junk in the reserved control bits, rewrites one key dword and re-enables the slot. The following lookup must show only that dword altered. Writes past the end of the array and into reserved dwords are followed by lookups that would expose any aliasing into slot 0.

// File: rtl/ks_pkg.sv
package ks_pkg;

    localparam int KEY_BITS    = 512;
    localparam int KEY_DWORDS  = 16;
    localparam int CTRL_DW     = 16;
    localparam int EXTRA_DW    = 17;
    localparam int ENTRY_BYTES = 128;

    typedef struct packed {
        logic       en;
        logic [7:0] cap_idx;
        logic [7:0] dus_mask;
    } slot_cfg_t;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_CAP  = 2'd1,
        RGN_SLOT = 2'd2
    } region_e;

    function automatic logic [31:0] pack_ctrl(slot_cfg_t c);
        return {c.en, 15'b0, c.cap_idx, c.dus_mask};
    endfunction

    function automatic slot_cfg_t unpack_ctrl(logic [31:0] w);
        slot_cfg_t c;
        c.en       = w[31];
        c.cap_idx  = w[15:8];
        c.dus_mask = w[7:0];
        return c;
    endfunction

endpackage

// File: rtl/ks_addr_decode.sv
module ks_addr_decode
    import ks_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_SLOTS = 4,
    parameter int ARRAY_PTR = 8,
    parameter int SLOT_W    = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [SLOT_W-1:0] slot,
    output logic [4:0]        dw
);
    localparam int BASE = ARRAY_PTR * 256;
    localparam int SPAN = NUM_SLOTS * ENTRY_BYTES;

    logic [ADDR_W:0] off;

    always_comb begin
        off    = {1'b0, addr} - (ADDR_W+1)'(BASE);
        region = RGN_NONE;
        if (addr[ADDR_W-1:2] == '0)
            region = RGN_CAP;
        else if (({1'b0, addr} >= (ADDR_W+1)'(BASE)) && (off < (ADDR_W+1)'(SPAN)))
            region = RGN_SLOT;
        slot = off[7 +: SLOT_W];
        dw   = off[6:2];
    end

endmodule

// File: rtl/ks_slot.sv
module ks_slot
    import ks_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [4:0]          dw,
    input  logic [31:0]         wdata,
    output logic [KEY_BITS-1:0] key,
    output slot_cfg_t           cfg,
    output logic [31:0]         rd_word
);
    logic [31:0] extra;

    always_ff @(posedge clk) begin
        if (rst) begin
            key   <= '0;
            cfg   <= '0;
            extra <= '0;
        end else if (wr_en) begin
            if (!dw[4]) begin
                if (!cfg.en)
                    key[dw[3:0]*32 +: 32] <= wdata;
            end else if (dw == 5'(CTRL_DW)) begin
                cfg <= unpack_ctrl(wdata);
            end else if (dw == 5'(EXTRA_DW)) begin
                if (!cfg.en)
                    extra <= wdata;
            end
        end
    end

    always_comb begin
        if (!dw[4])                     rd_word = '0;
        else if (dw == 5'(CTRL_DW))     rd_word = pack_ctrl(cfg);
        else if (dw == 5'(EXTRA_DW))    rd_word = extra;
        else                            rd_word = '0;
    end

    // R7
    locked_key_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !dw[4] && cfg.en) |=> $stable(key));

    // R7
    locked_extra_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dw == 5'(EXTRA_DW) && cfg.en) |=> $stable(extra));

    // R10
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (key == '0 && cfg == '0 && extra == '0));

endmodule

// File: rtl/ks_lookup.sv
module ks_lookup
    import ks_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int LK_IDX_W  = 8,
    parameter int SLOT_W    = 2
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [LK_IDX_W-1:0]                 lk_idx,
    input  logic [NUM_SLOTS-1:0][KEY_BITS-1:0]  keys,
    input  slot_cfg_t [NUM_SLOTS-1:0]           cfgs,
    output logic                                lk_valid,
    output logic [KEY_BITS-1:0]                 lk_key,
    output logic [7:0]                          lk_cap_idx,
    output logic [7:0]                          lk_dus_mask
);
    logic              in_range;
    logic [SLOT_W-1:0] sel;
    slot_cfg_t         c;

    always_comb begin
        in_range = ({1'b0, lk_idx} < (LK_IDX_W+1)'(NUM_SLOTS));
        sel      = lk_idx[SLOT_W-1:0];
        c        = cfgs[sel];
    end

    always_ff @(posedge clk) begin
        if (rst || !in_range || !c.en) begin
            lk_valid    <= 1'b0;
            lk_key      <= '0;
            lk_cap_idx  <= '0;
            lk_dus_mask <= '0;
        end else begin
            lk_valid    <= 1'b1;
            lk_key      <= keys[sel];
            lk_cap_idx  <= c.cap_idx;
            lk_dus_mask <= c.dus_mask;
        end
    end

    // R9
    out_of_range_chk: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, lk_idx} >= (LK_IDX_W+1)'(NUM_SLOTS)) |=> !lk_valid);

endmodule

// File: rtl/crypto_keyslot_regs.sv
module crypto_keyslot_regs
    import ks_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int ARRAY_PTR = 8,
    parameter int ADDR_W    = 12,
    parameter int LK_IDX_W  = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr_en,
    input  logic                reg_rd_en,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [LK_IDX_W-1:0] lk_idx,
    output logic                lk_valid,
    output logic [511:0]        lk_key,
    output logic [7:0]          lk_cap_idx,
    output logic [7:0]          lk_dus_mask
);
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam logic [31:0] CAP_WORD = {8'b0, 8'(ARRAY_PTR), 8'b0, 8'(NUM_SLOTS-1)};

    region_e           region;
    logic [SLOT_W-1:0] slot;
    logic [4:0]        dw;

    logic [NUM_SLOTS-1:0][KEY_BITS-1:0] keys;
    slot_cfg_t [NUM_SLOTS-1:0]          cfgs;
    logic [NUM_SLOTS-1:0][31:0]         slot_rd;

    ks_addr_decode #(
        .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS),
        .ARRAY_PTR(ARRAY_PTR), .SLOT_W(SLOT_W)
    ) u_dec (
        .addr(reg_addr), .region(region), .slot(slot), .dw(dw)
    );

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        logic sel_wr;
        assign sel_wr = reg_wr_en && (region == RGN_SLOT) && (slot == SLOT_W'(i));
        ks_slot u_slot (
            .clk(clk), .rst(rst), .wr_en(sel_wr), .dw(dw), .wdata(reg_wdata),
            .key(keys[i]), .cfg(cfgs[i]), .rd_word(slot_rd[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            reg_rdata <= '0;
        else if (reg_rd_en) begin
            case (region)
                RGN_CAP:  reg_rdata <= CAP_WORD;
                RGN_SLOT: reg_rdata <= slot_rd[slot];
                default:  reg_rdata <= '0;
            endcase
        end
    end

    ks_lookup #(
        .NUM_SLOTS(NUM_SLOTS), .LK_IDX_W(LK_IDX_W), .SLOT_W(SLOT_W)
    ) u_lk (
        .clk(clk), .rst(rst), .lk_idx(lk_idx), .keys(keys), .cfgs(cfgs),
        .lk_valid(lk_valid), .lk_key(lk_key),
        .lk_cap_idx(lk_cap_idx), .lk_dus_mask(lk_dus_mask)
    );

    // R3
    key_hidden_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_en && region == RGN_SLOT && !dw[4]) |=> (reg_rdata == '0));

    // R6
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_en && region == RGN_NONE) |=> (reg_rdata == '0));

    // R1
    cap_count_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_en && region == RGN_CAP) |=> (reg_rdata[7:0] == 8'(NUM_SLOTS-1)));

endmodule

// File: tb/tb_crypto_keyslot_regs.sv
`timescale 1ns/1ps
module tb_crypto_keyslot_regs;

    localparam int NS = 4;
    localparam int PTR = 8;
    localparam logic [11:0] BASE = 12'h800;

    logic         clk = 0;
    logic         rst = 1;
    logic         reg_wr_en = 0, reg_rd_en = 0;
    logic [11:0]  reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [7:0]   lk_idx = '0;
    logic         lk_go = 0;
    logic         lk_valid;
    logic [511:0] lk_key;
    logic [7:0]   lk_cap_idx, lk_dus_mask;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    crypto_keyslot_regs #(.NUM_SLOTS(NS), .ARRAY_PTR(PTR), .ADDR_W(12), .LK_IDX_W(8)) dut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_key(lk_key),
        .lk_cap_idx(lk_cap_idx), .lk_dus_mask(lk_dus_mask)
    );

    typedef struct { logic [31:0] exp; string req; } rexp_t;
    typedef struct { logic v; logic [7:0] cap; logic [7:0] dus; logic [511:0] key; string req; } lexp_t;
    rexp_t rq[$];
    lexp_t lq[$];

    function automatic logic [11:0] sa(int s, int d);
        return BASE + 12'(s * 128) + 12'(d * 4);
    endfunction

    function automatic logic [511:0] mk_key(int s);
        logic [511:0] k;
        for (int i = 0; i < 16; i++) k[32*i +: 32] = 32'hC0DE_0000 | (s << 8) | i;
        return k;
    endfunction

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk); reg_wr_en = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr_en = 0;
    endtask

    task automatic rd(logic [11:0] a, logic [31:0] e, string req);
        rexp_t x;
        x.exp = e; x.req = req;
        @(negedge clk); reg_rd_en = 1; reg_addr = a; rq.push_back(x);
        @(negedge clk); reg_rd_en = 0;
    endtask

    task automatic lk(logic [7:0] idx, logic v, logic [7:0] cap, logic [7:0] dus,
                      logic [511:0] key, string req);
        lexp_t x;
        x.v = v; x.cap = cap; x.dus = dus; x.key = key; x.req = req;
        @(negedge clk); lk_idx = idx; lk_go = 1; lq.push_back(x);
        @(negedge clk); lk_go = 0;
    endtask

    task automatic prog(int s, logic [7:0] dus, logic [7:0] cap);
        logic [511:0] k;
        k = mk_key(s);
        for (int i = 0; i < 16; i++) wr(sa(s, i), k[32*i +: 32]);
        wr(sa(s, 17), 32'hE000_0000 | s);
        wr(sa(s, 16), {1'b1, 15'b0, cap, dus});
    endtask

    // read monitor: result appears one cycle after the sampled strobe (R11)
    initial forever begin
        @(posedge clk);
        if (reg_rd_en && !rst) begin
            rexp_t x;
            #1;
            x = rq.pop_front();
            n_chk++;
            if (reg_rdata !== x.exp) begin
                n_fail++;
                $display("FAIL %s R11 rdata act=%h exp=%h", x.req, reg_rdata, x.exp);
            end
        end
    end

    // lookup monitor (R8)
    initial forever begin
        @(posedge clk);
        if (lk_go && !rst) begin
            lexp_t x;
            #1;
            x = lq.pop_front();
            n_chk++;
            if (lk_valid !== x.v || lk_cap_idx !== x.cap || lk_dus_mask !== x.dus || lk_key !== x.key) begin
                n_fail++;
                $display("FAIL %s lookup act v=%b cap=%h dus=%h key=%h exp v=%b cap=%h dus=%h key=%h",
                         x.req, lk_valid, lk_cap_idx, lk_dus_mask, lk_key, x.v, x.cap, x.dus, x.key);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [511:0] k0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        n_chk++;
        if (reg_rdata !== 32'h0) begin
            n_fail++; $display("FAIL R10 reset rdata act=%h exp=0", reg_rdata);
        end

        rd(12'h000, 32'h0008_0003, "R1");
        rd(12'h004, 32'h0, "R6");
        lk(0, 0, 0, 0, '0, "R10");
        lk(3, 0, 0, 0, '0, "R10");

        prog(0, 8'h08, 8'h02);
        rd(sa(0, 16), 32'h8000_0208, "R4");
        rd(sa(0, 17), 32'hE000_0000, "R5");
        rd(sa(0, 0), 32'h0, "R3");
        rd(sa(0, 15), 32'h0, "R3");
        lk(0, 1, 8'h02, 8'h08, mk_key(0), "R8");

        prog(3, 8'h01, 8'h05);
        rd(sa(3, 16), 32'h8000_0501, "R2");
        lk(3, 1, 8'h05, 8'h01, mk_key(3), "R2");
        lk(1, 0, 0, 0, '0, "R2");

        // R7: live slot rejects key and extra writes
        wr(sa(0, 0), 32'hDEAD_BEEF);
        wr(sa(0, 17), 32'h1234_5678);
        lk(0, 1, 8'h02, 8'h08, mk_key(0), "R7");
        rd(sa(0, 17), 32'hE000_0000, "R7");

        // disable with junk in reserved control bits
        wr(sa(0, 16), 32'h7FFF_0304);
        rd(sa(0, 16), 32'h0000_0304, "R4");
        lk(0, 0, 0, 0, '0, "R8");
        wr(sa(0, 0), 32'h1111_1111);
        wr(sa(0, 16), 32'h8000_0304);
        k0 = mk_key(0);
        k0[31:0] = 32'h1111_1111;
        lk(0, 1, 8'h03, 8'h04, k0, "R7");

        // R6: reserved dwords and unmapped space
        wr(sa(0, 18), 32'hFFFF_FFFF);
        rd(sa(0, 18), 32'h0, "R6");
        wr(12'h100, 32'hFFFF_FFFF);
        rd(12'h100, 32'h0, "R6");
        wr(12'hA40, 32'h0);
        wr(12'h7C0, 32'h0);
        rd(12'hA40, 32'h0, "R6");
        lk(0, 1, 8'h03, 8'h04, k0, "R6");
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h000, 32'h0008_0003, "R1");

        lk(4, 0, 0, 0, '0, "R9");
        lk(8'hFF, 0, 0, 0, '0, "R9");

        // reset in mid-run
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk); rst = 0;
        lk(0, 0, 0, 0, '0, "R10");
        lk(3, 0, 0, 0, '0, "R10");
        rd(sa(3, 17), 32'h0, "R10");
        wr(sa(0, 16), 32'h8000_0000);
        lk(0, 1, 8'h00, 8'h00, '0, "R10");

        repeat (3) @(negedge clk);
        n_chk++;
        if (rq.size() != 0 || lq.size() != 0) begin
            n_fail++;
            $display("FAIL R11 scoreboard left act=%0d exp=0", rq.size() + lq.size());
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule